// File: doc/BRIEF.md
# JESD204B Transmit Link Controller

This block sequences bring-up and recovery of a JESD204B transmit link. It keeps the frame and multiframe phase counters, runs a serializer PLL calibration window, and picks what the lane carries: comma characters (K28.5) for code group synchronization, the initial lane alignment (ILA) sequence, user samples, or nothing while asleep. The encoder, serializer and ILA payload sit downstream and follow the lane select and the multiframe strobe.

Once the converter core reports its calibration as finished, the controller starts the multiframe clock at a default phase and calibrates the PLL. It then sends commas and moves on to ILA at a multiframe boundary whenever the receiver's active-low SYNC line is released. A SYSREF rising edge is judged against the multiframe phase first and then against the frame phase. Only an edge that misses both restarts the phase counters and sends the link back through PLL calibration. A receiver that holds SYNC low long enough drops a running link back to commas. Sleep silences the lane and freezes the counters. Waking re-enters PLL calibration from the default phase.

Top module: `jesd_tx_link_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the state is OFF (0), the lane select is COMMA (0), both strobes are low and every status flag is 0.
- R2: The frame and multiframe counters are cleared while the state is OFF or SLEEP, and they start from zero in the first PLL-calibration cycle. `frame_end` is high in the last of every FRAME_SAMPLES cycles. `lmfc_end` is high in the last cycle of every MF_FRAMES frames. Both strobes stay low in OFF and SLEEP.
- R3: After `core_cal_done`, the state becomes PLLCAL (1) with lane COMMA. It stays there at least PLL_CAL_CYCLES cycles and until `pll_ready` is high, then moves to CGS (2) and sets the PLL-done flag.
- R4: In CGS the lane is COMMA. The state moves to ILA (3) in the cycle after an `lmfc_end` during which `sync_n` is high, and it stays in CGS while `sync_n` is low.
- R5: ILA (lane code 1) lasts ILA_MULTIFRAMES multiframes, then the state becomes DATA (4) with lane code 2 and the link-up flag set.
- R6: A SYSREF rising edge in a cycle with `lmfc_end` high changes neither the state nor the counters, and it leaves the misalignment flag clear.
- R7: A SYSREF rising edge in a cycle with `frame_end` high but `lmfc_end` low sets the sticky misalignment flag from the next cycle until reset. It leaves the state and the multiframe phase unchanged.
- R8: A SYSREF rising edge in a cycle with `frame_end` low, while in CGS, ILA or DATA, clears the counters for the next cycle. It also clears the PLL-done flag and enters PLLCAL, which then leads to commas and ILA without any SYNC request.
- R9: SYSREF edges in OFF, PLLCAL or SLEEP have no effect on state or phase.
- R10: In ILA or DATA, `sync_n` sampled low for SYNC_FRAMES*FRAME_SAMPLES consecutive cycles puts the state in CGS on the next cycle. A shorter low run has no effect.
- R11: `sleep_req` high in any state other than OFF gives SLEEP (5) next cycle, with lane SILENT (3) and the PLL-done flag cleared. The cycle after `sleep_req` is sampled low, the state is PLLCAL with the counters at zero.
- R12: `status` is {state[2:0], pll_done, link_up, sysref_miss}, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| core_cal_done | input | 1 | Converter core calibration finished |
| pll_ready | input | 1 | Serializer PLL reports calibration complete |
| sleep_req | input | 1 | Sleep request, level sensitive |
| sync_n | input | 1 | Receiver synchronization request, active low |
| sysref | input | 1 | SYSREF alignment input, rising edge significant |
| lane_sel | output | 2 | Lane content: 0 comma, 1 ILA, 2 data, 3 silent |
| frame_end | output | 1 | Last sample of a frame |
| lmfc_end | output | 1 | Last sample of a multiframe |
| status | output | 6 | {state, pll_done, link_up, sysref_miss} |

## Verification
The hardest case to reach from the ports is a SYSREF edge that is frame-aligned but multiframe-misaligned. It has to land on a sample where `frame_end` is high and `lmfc_end` is low, with the link already running. The bench counts cycles from the first PLL-calibration cycle, where the phase is known to be zero. It places that edge on a chosen sample and then confirms that the next multiframe boundary has not moved. Edges that miss the frame phase, and edges during calibration and sleep, are placed the same way. The bench then checks that the comma, ILA and data timing either restarts from zero or is left intact, as the requirement for that case says.

// File: rtl/jesd_link_pkg.sv
package jesd_link_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_PLLCAL = 3'd1,
        ST_CGS    = 3'd2,
        ST_ILA    = 3'd3,
        ST_DATA   = 3'd4,
        ST_SLEEP  = 3'd5
    } link_state_e;

    typedef enum logic [1:0] {
        LANE_COMMA  = 2'd0,
        LANE_ILA    = 2'd1,
        LANE_DATA   = 2'd2,
        LANE_SILENT = 2'd3
    } lane_sel_e;

    typedef struct packed {
        link_state_e state;
        logic        pll_done;
        logic        link_up;
        logic        sysref_miss;
    } link_status_t;

    function automatic lane_sel_e lane_for(link_state_e s);
        case (s)
            ST_ILA:   return LANE_ILA;
            ST_DATA:  return LANE_DATA;
            ST_SLEEP: return LANE_SILENT;
            default:  return LANE_COMMA;
        endcase
    endfunction

    // SYSREF is only evaluated while the link is between calibrations
    function automatic logic sysref_armed(link_state_e s);
        return (s == ST_CGS) || (s == ST_ILA) || (s == ST_DATA);
    endfunction

    // phase counters parked at zero
    function automatic logic phase_parked(link_state_e s);
        return (s == ST_OFF) || (s == ST_SLEEP);
    endfunction

endpackage

// File: rtl/lmfc_phase_gen.sv
module lmfc_phase_gen #(
    parameter int FRAME_SAMPLES = 2,
    parameter int MF_FRAMES     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic realign,
    output logic frame_end,
    output logic lmfc_end
);
    localparam int PW = (FRAME_SAMPLES > 1) ? $clog2(FRAME_SAMPLES) : 1;
    localparam int KW = (MF_FRAMES > 1) ? $clog2(MF_FRAMES) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(FRAME_SAMPLES - 1);
    localparam logic [KW-1:0] K_LAST = KW'(MF_FRAMES - 1);

    logic [PW-1:0] phase_q;
    logic [KW-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (rst || hold || realign) begin
            phase_q <= '0;
            frame_q <= '0;
        end else if (phase_q == P_LAST) begin
            phase_q <= '0;
            frame_q <= (frame_q == K_LAST) ? '0 : frame_q + 1'b1;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign frame_end = !hold && (phase_q == P_LAST);
    assign lmfc_end  = frame_end && (frame_q == K_LAST);

    generate
        if (FRAME_SAMPLES > 1) begin : g_gap
            AST_FRAME_GAP: assert property (@(posedge clk) disable iff (rst)
                (frame_end && !realign) |=> !frame_end); // R2
        end
    endgenerate

endmodule

// File: rtl/sysref_phase_check.sv
module sysref_phase_check (
    input  logic clk,
    input  logic rst,
    input  logic sysref,
    input  logic armed,
    input  logic at_frame_end,
    input  logic at_lmfc_end,
    output logic realign,
    output logic miss_sticky
);
    logic sysref_q;
    logic rise;
    logic lmfc_miss;

    always_ff @(posedge clk) begin
        if (rst) sysref_q <= 1'b0;
        else     sysref_q <= sysref;
    end

    assign rise      = sysref && !sysref_q && armed;
    assign lmfc_miss = rise && !at_lmfc_end;
    // frame phase only consulted once the multiframe phase has missed
    assign realign   = lmfc_miss && !at_frame_end;

    always_ff @(posedge clk) begin
        if (rst)            miss_sticky <= 1'b0;
        else if (lmfc_miss) miss_sticky <= 1'b1;
    end

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        miss_sticky |=> miss_sticky); // R7

endmodule

// File: rtl/sync_hold_detect.sv
module sync_hold_detect #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_n,
    output logic held
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] H_LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || sync_n)          low_cnt <= '0;
        else if (low_cnt != H_LAST) low_cnt <= low_cnt + 1'b1;
    end

    assign held = !sync_n && (low_cnt == H_LAST);

endmodule

// File: rtl/jesd_tx_link_ctrl.sv
module jesd_tx_link_ctrl
    import jesd_link_pkg::*;
#(
    parameter int FRAME_SAMPLES   = 2,
    parameter int MF_FRAMES       = 16,
    parameter int PLL_CAL_CYCLES  = 153000,
    parameter int SYNC_FRAMES     = 4,
    parameter int ILA_MULTIFRAMES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       core_cal_done,
    input  logic       pll_ready,
    input  logic       sleep_req,
    input  logic       sync_n,
    input  logic       sysref,
    output logic [1:0] lane_sel,
    output logic       frame_end,
    output logic       lmfc_end,
    output logic [5:0] status
);
    localparam int PCW = $clog2(PLL_CAL_CYCLES + 1);
    localparam int IW  = (ILA_MULTIFRAMES > 1) ? $clog2(ILA_MULTIFRAMES) : 1;
    localparam logic [PCW-1:0] PLL_LAST = PCW'(PLL_CAL_CYCLES - 1);
    localparam logic [IW-1:0]  ILA_LAST = IW'(ILA_MULTIFRAMES - 1);

    link_state_e   state_q, nxt;
    logic [PCW-1:0] pll_cnt;
    logic [IW-1:0]  ila_cnt;
    logic           pll_done_q;
    logic           realign;
    logic           sync_held;
    logic           miss_sticky;
    link_status_t   st_w;

    lmfc_phase_gen #(
        .FRAME_SAMPLES (FRAME_SAMPLES),
        .MF_FRAMES     (MF_FRAMES)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .hold      (phase_parked(state_q)),
        .realign   (realign),
        .frame_end (frame_end),
        .lmfc_end  (lmfc_end)
    );

    sysref_phase_check u_sref (
        .clk          (clk),
        .rst          (rst),
        .sysref       (sysref),
        .armed        (sysref_armed(state_q)),
        .at_frame_end (frame_end),
        .at_lmfc_end  (lmfc_end),
        .realign      (realign),
        .miss_sticky  (miss_sticky)
    );

    sync_hold_detect #(
        .HOLD_CYCLES (SYNC_FRAMES * FRAME_SAMPLES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sync_n (sync_n),
        .held   (sync_held)
    );

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_OFF:    if (core_cal_done) nxt = ST_PLLCAL;
            ST_PLLCAL: if (pll_cnt == PLL_LAST && pll_ready) nxt = ST_CGS;
            ST_CGS:    if (lmfc_end && sync_n) nxt = ST_ILA;
            ST_ILA:    if (lmfc_end && ila_cnt == ILA_LAST) nxt = ST_DATA;
            ST_DATA:   nxt = ST_DATA;
            ST_SLEEP:  if (!sleep_req) nxt = ST_PLLCAL;
            default:   nxt = ST_OFF;
        endcase
        if (realign)
            nxt = ST_PLLCAL;
        else if (sync_held && (state_q == ST_ILA || state_q == ST_DATA))
            nxt = ST_CGS;
        if (sleep_req && state_q != ST_OFF)
            nxt = ST_SLEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || state_q != ST_PLLCAL) pll_cnt <= '0;
        else if (pll_cnt != PLL_LAST)    pll_cnt <= pll_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || state_q != ST_ILA) ila_cnt <= '0;
        else if (lmfc_end)            ila_cnt <= ila_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pll_done_q <= 1'b0;
        else if (nxt == ST_OFF || nxt == ST_PLLCAL || nxt == ST_SLEEP)
            pll_done_q <= 1'b0;
        else if (state_q == ST_PLLCAL)
            pll_done_q <= 1'b1;
    end

    assign st_w = '{state: state_q, pll_done: pll_done_q,
                    link_up: (state_q == ST_DATA), sysref_miss: miss_sticky};
    assign status   = st_w;
    assign lane_sel = lane_for(state_q);

    AST_PLLCAL_MIN_LEN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CGS && $past(state_q) == ST_PLLCAL) |-> ($past(pll_cnt) == PLL_LAST)); // R3
    AST_ILA_ON_LMFC: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ILA && $past(state_q) == ST_CGS) |-> $past(lmfc_end)); // R4
    AST_DATA_AFTER_ILA: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_DATA) |-> ($past(state_q) == ST_ILA)); // R5
    AST_BREAK_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CGS && ($past(state_q) == ST_ILA || $past(state_q) == ST_DATA))
            |-> !$past(sync_n)); // R10
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && state_q != ST_OFF) |=> (state_q == ST_SLEEP)); // R11
    AST_SILENT_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (lane_sel == 2'd3) |-> $past(sleep_req)); // R11

endmodule

// File: tb/sim_jesd_tx_link_ctrl.sv
module sim_jesd_tx_link_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       core_cal_done = 1'b0;
    logic       pll_ready = 1'b1;
    logic       sleep_req = 1'b0;
    logic       sync_n = 1'b1;
    logic       sysref = 1'b0;
    logic [1:0] lane_sel;
    logic       frame_end;
    logic       lmfc_end;
    logic [5:0] status;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam int K_ST = 0, K_LANE = 1, K_LMFC = 2, K_PLL = 3,
                   K_LINK = 4, K_MISS = 5, K_FRAME = 6;

    typedef struct {
        int    at;
        int    kind;
        int    val;
        string req;
    } exp_t;

    exp_t q[$];
    exp_t it;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    jesd_tx_link_ctrl #(
        .FRAME_SAMPLES   (2),
        .MF_FRAMES       (4),
        .PLL_CAL_CYCLES  (10),
        .SYNC_FRAMES     (4),
        .ILA_MULTIFRAMES (4)
    ) u0 (
        .clk           (clk),
        .rst           (rst),
        .core_cal_done (core_cal_done),
        .pll_ready     (pll_ready),
        .sleep_req     (sleep_req),
        .sync_n        (sync_n),
        .sysref        (sysref),
        .lane_sel      (lane_sel),
        .frame_end     (frame_end),
        .lmfc_end      (lmfc_end),
        .status        (status)
    );

    function automatic int observe(int kind);
        case (kind)
            K_ST:    return int'(status[5:3]);
            K_LANE:  return int'(lane_sel);
            K_LMFC:  return int'(lmfc_end);
            K_PLL:   return int'(status[2]);
            K_LINK:  return int'(status[1]);
            K_MISS:  return int'(status[0]);
            default: return int'(frame_end);
        endcase
    endfunction

    task automatic expect_at(int at, int kind, int val, string req);
        q.push_back('{at, kind, val, req});
    endtask

    task automatic wait_cyc(int n);
        while (cyc != n) @(negedge clk);
    endtask

    // monitor: pop expected items whose cycle has come and compare
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            it = q.pop_front();
            checks++;
            if (it.at < cyc) begin
                failures++;
                $display("FAIL %s kind=%0d missed at cycle %0d actual=none expected=%0d",
                         it.req, it.kind, it.at, it.val);
            end else if (observe(it.kind) != it.val) begin
                failures++;
                $display("FAIL %s kind=%0d cycle=%0d actual=%0d expected=%0d",
                         it.req, it.kind, cyc, observe(it.kind), it.val);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int b, c, d, e;
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_at(4, K_ST, 0, "R1");
        expect_at(4, K_LANE, 0, "R1");
        expect_at(4, K_PLL, 0, "R1");
        expect_at(4, K_LINK, 0, "R1");
        expect_at(4, K_MISS, 0, "R1");
        expect_at(4, K_LMFC, 0, "R1");
        rst = 1'b0;

        wait_cyc(6);
        core_cal_done = 1'b1;
        b = 7;
        expect_at(b,      K_ST, 1, "R3");
        expect_at(b,      K_PLL, 0, "R12");
        expect_at(b,      K_FRAME, 0, "R2");
        expect_at(b + 1,  K_FRAME, 1, "R2");
        expect_at(b + 6,  K_LMFC, 0, "R2");
        expect_at(b + 7,  K_LMFC, 1, "R2");
        expect_at(b + 9,  K_ST, 1, "R3");
        expect_at(b + 10, K_ST, 2, "R3");
        expect_at(b + 10, K_PLL, 1, "R3");
        expect_at(b + 10, K_LANE, 0, "R4");
        expect_at(b + 15, K_ST, 2, "R4");
        expect_at(b + 15, K_LMFC, 1, "R2");
        expect_at(b + 16, K_ST, 3, "R4");
        expect_at(b + 16, K_LANE, 1, "R5");
        expect_at(b + 47, K_ST, 3, "R5");
        expect_at(b + 48, K_ST, 4, "R5");
        expect_at(b + 48, K_LANE, 2, "R5");
        expect_at(b + 48, K_LINK, 1, "R12");

        wait_cyc(b + 55);               // aligned with multiframe end
        sysref = 1'b1;
        expect_at(b + 56, K_ST, 4, "R6");
        expect_at(b + 56, K_MISS, 0, "R6");
        wait_cyc(b + 56);
        sysref = 1'b0;

        wait_cyc(b + 57);               // frame end, not multiframe end
        sysref = 1'b1;
        expect_at(b + 58, K_MISS, 1, "R7");
        expect_at(b + 58, K_ST, 4, "R7");
        expect_at(b + 62, K_LMFC, 0, "R7");
        expect_at(b + 63, K_LMFC, 1, "R7");
        wait_cyc(b + 58);
        sysref = 1'b0;

        wait_cyc(b + 66);               // mid frame: full misalignment
        sysref = 1'b1;
        c = b + 67;
        expect_at(c, K_ST, 1, "R8");
        expect_at(c, K_PLL, 0, "R8");
        expect_at(c, K_LANE, 0, "R8");
        wait_cyc(c);
        sysref = 1'b0;

        wait_cyc(c + 3);                // edge during calibration, hold SYNC low
        sysref = 1'b1;
        sync_n = 1'b0;
        expect_at(c + 7,  K_LMFC, 1, "R8");
        expect_at(c + 9,  K_ST, 1, "R9");
        expect_at(c + 10, K_ST, 2, "R9");
        expect_at(c + 15, K_LMFC, 1, "R4");
        expect_at(c + 15, K_ST, 2, "R4");
        expect_at(c + 16, K_ST, 2, "R4");
        wait_cyc(c + 4);
        sysref = 1'b0;

        wait_cyc(c + 20);
        sync_n = 1'b1;
        expect_at(c + 23, K_ST, 2, "R4");
        expect_at(c + 24, K_ST, 3, "R4");
        expect_at(c + 55, K_ST, 3, "R5");
        expect_at(c + 56, K_ST, 4, "R5");

        d = c;
        wait_cyc(d + 60);               // 7 low cycles: too short
        sync_n = 1'b0;
        wait_cyc(d + 67);
        sync_n = 1'b1;
        expect_at(d + 68, K_ST, 4, "R10");
        expect_at(d + 69, K_ST, 4, "R10");

        wait_cyc(d + 70);               // 8 low cycles: break
        sync_n = 1'b0;
        expect_at(d + 77, K_ST, 4, "R10");
        expect_at(d + 78, K_ST, 2, "R10");
        expect_at(d + 78, K_LANE, 0, "R10");
        expect_at(d + 78, K_LINK, 0, "R10");
        wait_cyc(d + 80);
        sync_n = 1'b1;
        expect_at(d + 87, K_ST, 2, "R4");
        expect_at(d + 88, K_ST, 3, "R4");

        wait_cyc(d + 90);
        sleep_req = 1'b1;
        expect_at(d + 91, K_ST, 5, "R11");
        expect_at(d + 91, K_LANE, 3, "R11");
        expect_at(d + 91, K_PLL, 0, "R11");
        expect_at(d + 91, K_LINK, 0, "R11");
        expect_at(d + 95, K_LMFC, 0, "R2");
        expect_at(d + 96, K_ST, 5, "R9");
        wait_cyc(d + 93);
        sysref = 1'b1;
        wait_cyc(d + 94);
        sysref = 1'b0;
        wait_cyc(d + 96);
        pll_ready = 1'b0;
        wait_cyc(d + 97);
        sleep_req = 1'b0;
        e = d + 98;
        expect_at(e,      K_ST, 1, "R11");
        expect_at(e,      K_PLL, 0, "R11");
        expect_at(e + 7,  K_LMFC, 1, "R11");
        expect_at(e + 14, K_ST, 1, "R3");
        expect_at(e + 14, K_PLL, 0, "R3");
        wait_cyc(e + 14);
        pll_ready = 1'b1;
        expect_at(e + 15, K_ST, 2, "R3");
        expect_at(e + 15, K_PLL, 1, "R3");
        expect_at(e + 16, K_ST, 3, "R4");
        expect_at(e + 16, K_MISS, 1, "R7");

        wait_cyc(e + 20);
        while (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            failures++;
            $display("FAIL %s kind=%0d never checked actual=none expected=%0d",
                     it.req, it.kind, it.val);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule